// File: doc/BRIEF.md
# Double-Buffered Edge-Aligned PWM Channel

This block produces one pulse-width-modulated output from a 16-bit up-counting period timer. Software loads three registers through a single-cycle write port: a primary compare value, a secondary compare value that sets the duty, and the period limit. The timer counts from zero up to the period limit, inclusive, and then starts again at zero. Each new period is called a wrap. The output goes high at each wrap and goes low when the timer reaches the working secondary compare value.

The compare values are double-buffered. The values software writes are copied into the working registers only at a wrap, so a write made in the middle of a period cannot cut a pulse short. The working primary compare value is driven out on a port so that neighbouring logic can read it. Every wrap sets a sticky interrupt flag, which is cleared by a strobe. An enable input starts and stops the channel.

The sequencer has two states. `ST_IDLE` is the disabled state: the timer is held at zero and the output is low. `ST_RUN` is the counting state. The transitions are named as follows:
- **start** (ST_IDLE to ST_RUN): taken when the enable is high. It is itself a wrap.
- **wrap** (ST_RUN to ST_RUN): taken when the timer equals the period value.
- **advance** (ST_RUN to ST_RUN): increments the timer.
- **stop** (either state to ST_IDLE): taken when the enable is low.

Top module: `ecpwm_channel`

## Requirements
- R1: When `wr_en` is high, `wr_data` is stored in the software register chosen by `wr_sel`. The codes are 0 for the primary compare, 1 for the secondary compare and 2 for the period. Code 3 is ignored. Writes are accepted in any state.
- R2: In ST_RUN, when the timer equals the period value, the timer returns to 0 on the next cycle. One period therefore lasts period+1 cycles.
- R3: The working compare registers are loaded from the software registers only at a wrap (start or wrap transition). `work_pri` shows the working primary value and changes at no other time.
- R4: At a wrap, `pwm_out` goes high unless the secondary value being loaded is zero. It goes low in the cycle in which the timer equals the working secondary value. Within a period it is high for the first min(sec, period+1) cycles.
- R5: When the working secondary value is zero, `pwm_out` stays low. This includes the case where all three registers are zero (0% duty).
- R6: When the secondary value exceeds the period value, `pwm_out` stays high for the whole period (100% duty).
- R7: `irq_flag` is set at every wrap and stays set until `irq_clr` is pulsed. When a wrap and a clear happen in the same cycle, the flag is set. Reaching the compare value does not set the flag.
- R8: While `en` is low, the timer is held at 0, `pwm_out` is low, and the working registers keep their values. Raising `en` starts a new period with a wrap.
- R9: A synchronous `rst` clears the timer, all compare and period registers, the interrupt flag and the output. The first period after reset runs with these zero values loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Channel enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 primary, 1 secondary, 2 period |
| wr_data | input | 16 | Write data |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| pwm_out | output | 1 | PWM output |
| irq_flag | output | 1 | Sticky wrap interrupt flag |
| work_pri | output | 16 | Working (buffered) primary compare value |

## Verification
The bench sweeps every combination of period 0 to 5 with secondary compare 0 to 7, over two whole periods. This separates the zero-duty case, partial duty, the exact-fit case where sec equals period+1, and the over-range 100% case. A mid-period rewrite of both compare values shows that the current period keeps the old duty and the next period picks up the new one. Clear pulses placed away from a wrap and on a wrap separate the plain clear from the set-wins rule. Writes made while disabled show that the working registers hold their values until the channel is enabled again.

// File: rtl/ecpwm_pkg.sv
package ecpwm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    localparam logic [1:0] SEL_PRI = 2'd0;
    localparam logic [1:0] SEL_SEC = 2'd1;
    localparam logic [1:0] SEL_PER = 2'd2;
endpackage

// File: rtl/ecpwm_regs.sv
module ecpwm_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] sw_pri,
    output logic [W-1:0] sw_sec,
    output logic [W-1:0] sw_per
);
    import ecpwm_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_pri <= '0;
            sw_sec <= '0;
            sw_per <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_PRI: sw_pri <= wr_data;
                SEL_SEC: sw_sec <= wr_data;
                SEL_PER: sw_per <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ecpwm_sequencer.sv
module ecpwm_sequencer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] period,
    output logic [W-1:0] tmr,
    output logic         wrap,
    output logic         advance
);
    import ecpwm_pkg::*;

    seq_state_t   state_q, state_d;
    logic [W-1:0] tmr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tmr     <= '0;
        end else begin
            state_q <= state_d;
            tmr     <= tmr_d;
        end
    end

    always_comb begin
        wrap    = 1'b0;
        advance = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_d = ST_RUN;
                    wrap    = 1'b1;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (tmr == period) begin
                    wrap = 1'b1;
                end else begin
                    advance = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        tmr_d = advance ? tmr + 1'b1 : '0;
    end
endmodule

// File: rtl/ecpwm_shadow.sv
module ecpwm_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         wrap,
    input  logic         advance,
    input  logic [W-1:0] tmr,
    input  logic [W-1:0] sw_pri,
    input  logic [W-1:0] sw_sec,
    input  logic         irq_clr,
    output logic [W-1:0] buf_pri,
    output logic [W-1:0] buf_sec,
    output logic         pin,
    output logic         irq
);
    logic [W-1:0] tmr_inc;
    logic         duty_hit;

    always_comb begin
        tmr_inc  = tmr + 1'b1;
        duty_hit = advance && (tmr_inc == buf_sec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_pri <= '0;
            buf_sec <= '0;
            pin     <= 1'b0;
        end else if (!en) begin
            pin <= 1'b0;
        end else if (wrap) begin
            buf_pri <= sw_pri;
            buf_sec <= sw_sec;
            pin     <= (sw_sec != '0);
        end else if (duty_hit) begin
            pin <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (wrap)    irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end
endmodule

// File: rtl/ecpwm_channel.sv
module ecpwm_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         irq_clr,
    output logic         pwm_out,
    output logic         irq_flag,
    output logic [W-1:0] work_pri
);
    logic [W-1:0] sw_pri, sw_sec, sw_per, tmr, buf_sec;
    logic         wrap, advance;

    ecpwm_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sw_pri(sw_pri), .sw_sec(sw_sec), .sw_per(sw_per)
    );

    ecpwm_sequencer #(.W(W)) u_seq (
        .clk(clk), .rst(rst), .en(en), .period(sw_per),
        .tmr(tmr), .wrap(wrap), .advance(advance)
    );

    ecpwm_shadow #(.W(W)) u_shadow (
        .clk(clk), .rst(rst), .en(en), .wrap(wrap), .advance(advance), .tmr(tmr),
        .sw_pri(sw_pri), .sw_sec(sw_sec), .irq_clr(irq_clr),
        .buf_pri(work_pri), .buf_sec(buf_sec), .pin(pwm_out), .irq(irq_flag)
    );
endmodule

// File: rtl/ecpwm_channel_chk.sv
module ecpwm_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         irq_clr,
    input logic         pwm_out,
    input logic         irq_flag,
    input logic [W-1:0] work_pri,
    input logic [W-1:0] buf_sec,
    input logic         wrap
);
    // R8
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_out);

    // R7
    rise_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> irq_flag);

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R3
    shadow_only_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(work_pri) |-> $past(wrap));

    // R5
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_sec == '0) |-> !pwm_out);
endmodule

bind ecpwm_channel ecpwm_channel_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .irq_clr(irq_clr), .pwm_out(pwm_out),
    .irq_flag(irq_flag), .work_pri(work_pri), .buf_sec(buf_sec), .wrap(wrap)
);

// File: tb/ecpwm_channel_test.sv
`timescale 1ns/1ps
module ecpwm_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        irq_clr = 1'b0;
    logic        pwm_out, irq_flag;
    logic [15:0] work_pri;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    ecpwm_channel uut (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq_clr(irq_clr), .pwm_out(pwm_out),
        .irq_flag(irq_flag), .work_pri(work_pri)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R9 reset state
        check("R9 pin after reset", pwm_out, 0);
        check("R9 irq after reset", irq_flag, 0);
        check("R9 work_pri after reset", work_pri, 0);
        rst = 1'b0;
        en = 1'b1;
        @(negedge clk);
        // R5/R9 all-zero first period: 0% duty, wrap every cycle
        for (int k = 0; k < 6; k++) begin
            check("R5 all-zero pin low", pwm_out, 0);
            check("R9 irq at reset-valued wrap", irq_flag, 1);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
        end

        // R2 R4 R5 R6 sweep
        for (int p = 0; p <= 5; p++) begin
            for (int s = 0; s <= 7; s++) begin
                en = 1'b0;
                @(negedge clk);
                check("R8 pin low while disabled", pwm_out, 0);
                wr(2'd2, 16'(p));
                wr(2'd1, 16'(s));
                wr(2'd3, 16'hFFFF);  // R1 code 3 ignored
                en = 1'b1;
                @(negedge clk);
                for (int c = 0; c < 2 * (p + 1); c++) begin
                    int k;
                    k = c % (p + 1);
                    if (s == 0)
                        check("R5 zero duty low", pwm_out, 0);
                    else if (s > p)
                        check("R6 full duty high", pwm_out, 1);
                    else
                        check("R4 R2 duty shape", pwm_out, (k < s) ? 1 : 0);
                    if (k == 0) check("R7 irq at wrap", irq_flag, 1);
                    @(negedge clk);
                end
            end
        end

        // R1 R3 deferred update
        en = 1'b0;
        @(negedge clk);
        wr(2'd0, 16'd0);
        wr(2'd2, 16'd7);
        wr(2'd1, 16'd3);
        en = 1'b1;
        @(negedge clk);                 // k = 0
        wr(2'd0, 16'h1234);             // k = 1
        wr(2'd1, 16'd6);                // k = 2
        for (int k = 2; k <= 7; k++) begin
            check("R3 old duty kept until wrap", pwm_out, (k < 3) ? 1 : 0);
            check("R3 work_pri held until wrap", work_pri, 0);
            @(negedge clk);
        end
        check("R1 R3 work_pri loaded at wrap", work_pri, 16'h1234);
        for (int k = 0; k <= 7; k++) begin
            check("R3 new duty after wrap", pwm_out, (k < 6) ? 1 : 0);
            @(negedge clk);
        end

        // R7 clear and set-wins (now at k = 0 of a period of 8)
        @(negedge clk);
        @(negedge clk);                 // k = 2
        irq_clr = 1'b1;
        @(negedge clk);                 // k = 3
        irq_clr = 1'b0;
        check("R7 clear away from wrap", irq_flag, 0);
        repeat (4) @(negedge clk);      // k = 7
        check("R7 compare match sets no irq", irq_flag, 0);
        irq_clr = 1'b1;
        @(negedge clk);                 // k = 0
        irq_clr = 1'b0;
        check("R7 set wins over clear", irq_flag, 1);

        // R8 writes while disabled
        en = 1'b0;
        @(negedge clk);
        wr(2'd0, 16'hBEEF);
        for (int k = 0; k < 4; k++) begin
            check("R8 pin low disabled", pwm_out, 0);
            check("R8 work_pri held disabled", work_pri, 16'h1234);
            @(negedge clk);
        end
        en = 1'b1;
        @(negedge clk);
        check("R8 restart loads work_pri", work_pri, 16'hBEEF);
        check("R8 restart pin high", pwm_out, 1);
        check("R8 restart irq", irq_flag, 1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule